// File: doc/BRIEF.md
# Keypad Matrix Scan Sequencer

This block runs the key matrix of a handheld remote-control encoder. Eight key-sense lines and four system-sense lines, all active low, sit across eight scan drivers. While nothing is happening every driver conducts, so any single pressed contact pulls its sense line low. A legal press is held through a debounce window of whole bit-times. After that the block walks the drivers one at a time for two scan passes and turns the contact it finds into a system number and a command number.

In combined mode a contact on a system line latches the system number and forces the all-ones command. A contact on a key line produces a command that goes out with the system number already stored. In single-system mode the system lines never start anything. The first pass enables only their pull-ups and reads a wired system strap. The second pass enables only the key pull-ups and reads the command. A one-cycle request marks each finished code. While the key stays down the scans repeat after a fixed number of bit-times, so a different key taken over in the meantime is reported correctly. Bit-times come from an external one-cycle enable, and the scan slots are counted in clock cycles.

Top module: `keypad_scan_seq`

## Requirements
- R1: After reset and while quiescent, all drivers conduct (`drv_on` all ones), `code_req`, `session_on` and `abort_pulse` are low, and `sys_id` and `cmd_id` are 0.
- R2: A press starts only when exactly one enabled sense line is low. Two key lines low together, or a key line together with a system line, start nothing: no session, no request and no abort.
- R3: Debounce lasts `DEB_BITS` bit ticks and is followed by two scan passes of `BIT_CLKS` cycles each. The first `code_req` comes between 17 and 18 bit-times after the press, with a few cycles of margin.
- R4: A release (or any loss of a legal pattern) during debounce gives a one-cycle `abort_pulse`, and the block returns to quiescence without a request.
- R5: During a scan exactly one driver is on. The drivers go in rising index order, wrap from the last to index 0 between passes, and each stays on for `BIT_CLKS/N_DRV` cycles.
- R6: A key-line hit gives `cmd_id` = driver index × 8 + key-line index. If one sense line meets several drivers, the last driver in scan order wins, including the last driver of the last pass.
- R7: In combined mode (`mode_single`=0), a system-line hit gives `sys_id` = system-line index × 8 + driver index and `cmd_id` = 63.
- R8: In combined mode, a key press keeps the stored system number (0 after reset).
- R9: In single mode (`mode_single`=1), a system-line contact alone never starts a session. The first pass has only `sys_pu_en` high and latches the wired strap. The second pass has only `key_pu_en` high and latches the command.
- R10: In single mode, if no wired strap is found in the first pass, `abort_pulse` fires and no request is made.
- R11: While a legal press remains, the scans repeat every `REPEAT_BITS` bit ticks plus the scan time. A key swapped in before the repeat is the one reported.
- R12: `session_on` is high from the end of debounce until the first repeat point with no press, and that end raises no `abort_pulse`.
- R13: `code_req` lasts one cycle and never coincides with `abort_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bit_tick | input | 1 | One-cycle enable per bit-time |
| mode_single | input | 1 | 1 = single-system mode, 0 = combined mode |
| key_sense_n | input | N_KEY | Key-sense lines, active low |
| sys_sense_n | input | N_SYS | System-sense lines, active low |
| drv_on | output | N_DRV | Scan driver conduct enables, 1 = pulling low |
| key_pu_en | output | 1 | Key-line pull-up enable |
| sys_pu_en | output | 1 | System-line pull-up enable |
| sys_id | output | SYS_W | Latched system number |
| cmd_id | output | CMD_W | Latched command number |
| code_req | output | 1 | One-cycle request: a code is ready |
| session_on | output | 1 | Key held: scanning or between codes |
| abort_pulse | output | 1 | One-cycle indication of an abnormal reset |

## Verification
The sample of the last driver slot of the second pass falls in the same cycle as the decision that ends the scan. That one edge must both latch the hit and raise the request, or abort if nothing was seen. The bench provokes this with contacts on the last driver: a key line strapped to drivers 2 and 7 in combined mode, and a key on driver 7 in single mode. It judges the result by the command captured on the very cycle `code_req` is high, which must already hold the driver-7 value (57 and 56). In single mode, a missing strap makes the first-pass end and the abort coincide, and the bench expects an abort with no request.

// File: rtl/kpd_pkg.sv
package kpd_pkg;
   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_DEB  = 2'd1,
      ST_SCAN = 2'd2,
      ST_WAIT = 2'd3
   } kpd_state_e;
endpackage

// File: rtl/kpd_sense.sv
// Masks sense lines by their pull-up enables, judges legality, encodes the low line.
module kpd_sense #(
   parameter int N_KEY = 8,
   parameter int N_SYS = 4,
   localparam int KEY_W = (N_KEY > 1) ? $clog2(N_KEY) : 1,
   localparam int SIDX_W = (N_SYS > 1) ? $clog2(N_SYS) : 1
) (
   input  logic [N_KEY-1:0]  key_n,
   input  logic [N_SYS-1:0]  sys_n,
   input  logic              key_en,
   input  logic              sys_en,
   output logic              legal,
   output logic              is_sys,
   output logic [KEY_W-1:0]  key_idx,
   output logic [SIDX_W-1:0] sys_idx
);
   logic [N_KEY-1:0] key_act;
   logic [N_SYS-1:0] sys_act;
   int               n_low;

   assign key_act = ~key_n & {N_KEY{key_en}};
   assign sys_act = ~sys_n & {N_SYS{sys_en}};

   always_comb begin
      n_low = $countones(key_act) + $countones(sys_act);
      legal = (n_low == 1);
      is_sys = |sys_act;
   end

   always_comb begin
      key_idx = '0;
      for (int i = 0; i < N_KEY; i++)
         if (key_act[i]) key_idx = KEY_W'(i);
   end

   always_comb begin
      sys_idx = '0;
      for (int i = 0; i < N_SYS; i++)
         if (sys_act[i]) sys_idx = SIDX_W'(i);
   end
endmodule

// File: rtl/kpd_drv_seq.sv
// Walks the scan drivers one slot at a time for as long as run is high.
module kpd_drv_seq #(
   parameter int N_DRV = 8,
   parameter int SLOT_CLKS = 96,
   localparam int DRV_W = (N_DRV > 1) ? $clog2(N_DRV) : 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             run,
   output logic [DRV_W-1:0] drv_idx,
   output logic             scan_no,
   output logic             slot_end,
   output logic [N_DRV-1:0] drv_onehot
);
   generate
      if (SLOT_CLKS == 1) begin : g_slot_one
         assign slot_end = run;
      end else begin : g_slot_cnt
         localparam int SW = $clog2(SLOT_CLKS);
         logic [SW-1:0] slot_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) slot_q <= '0;
            else if (!run || slot_q == SW'(SLOT_CLKS - 1)) slot_q <= '0;
            else slot_q <= slot_q + 1'b1;
         end
         assign slot_end = run && (slot_q == SW'(SLOT_CLKS - 1));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         drv_idx <= '0;
         scan_no <= 1'b0;
      end else if (!run) begin
         drv_idx <= '0;
         scan_no <= 1'b0;
      end else if (slot_end) begin
         if (drv_idx == DRV_W'(N_DRV - 1)) begin
            drv_idx <= '0;
            scan_no <= ~scan_no;
         end else begin
            drv_idx <= drv_idx + 1'b1;
         end
      end
   end

   for (genvar g = 0; g < N_DRV; g++) begin : g_onehot
      assign drv_onehot[g] = (drv_idx == DRV_W'(g));
   end
endmodule

// File: rtl/keypad_scan_seq.sv
module keypad_scan_seq #(
   parameter int N_DRV = 8,
   parameter int N_KEY = 8,
   parameter int N_SYS = 4,
   parameter int DEB_BITS = 16,
   parameter int BIT_CLKS = 768,
   parameter int REPEAT_BITS = 64,
   localparam int SYS_W = $clog2(N_SYS * N_DRV),
   localparam int CMD_W = $clog2(N_DRV * N_KEY)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             bit_tick,
   input  logic             mode_single,
   input  logic [N_KEY-1:0] key_sense_n,
   input  logic [N_SYS-1:0] sys_sense_n,
   output logic [N_DRV-1:0] drv_on,
   output logic             key_pu_en,
   output logic             sys_pu_en,
   output logic [SYS_W-1:0] sys_id,
   output logic [CMD_W-1:0] cmd_id,
   output logic             code_req,
   output logic             session_on,
   output logic             abort_pulse
);
   import kpd_pkg::*;

   localparam int DRV_W = (N_DRV > 1) ? $clog2(N_DRV) : 1;
   localparam int KEY_W = (N_KEY > 1) ? $clog2(N_KEY) : 1;
   localparam int SIDX_W = (N_SYS > 1) ? $clog2(N_SYS) : 1;
   localparam int SLOT_CLKS = BIT_CLKS / N_DRV;
   localparam int CNT_MAX = (DEB_BITS > REPEAT_BITS) ? DEB_BITS : REPEAT_BITS;
   localparam int CNT_W = $clog2(CNT_MAX + 1);

   if (BIT_CLKS % N_DRV != 0) begin : g_bad_slot
      $error("BIT_CLKS must be a multiple of N_DRV");
   end
   if (DEB_BITS < 1 || REPEAT_BITS < 1) begin : g_bad_cnt
      $error("DEB_BITS and REPEAT_BITS must be at least 1");
   end

   kpd_state_e       state;
   logic [CNT_W-1:0] tick_cnt;
   logic             sys_hit_q, key_hit_q;

   logic              legal, is_sys;
   logic [KEY_W-1:0]  key_idx;
   logic [SIDX_W-1:0] sys_idx;
   logic [DRV_W-1:0]  drv_idx;
   logic              scan_no, slot_end;
   logic [N_DRV-1:0]  drv_onehot;

   kpd_sense #(.N_KEY(N_KEY), .N_SYS(N_SYS)) u_sense (
      .key_n(key_sense_n), .sys_n(sys_sense_n),
      .key_en(key_pu_en), .sys_en(sys_pu_en),
      .legal(legal), .is_sys(is_sys), .key_idx(key_idx), .sys_idx(sys_idx)
   );

   kpd_drv_seq #(.N_DRV(N_DRV), .SLOT_CLKS(SLOT_CLKS)) u_seq (
      .clk(clk), .rst_n(rst_n), .run(state == ST_SCAN),
      .drv_idx(drv_idx), .scan_no(scan_no), .slot_end(slot_end),
      .drv_onehot(drv_onehot)
   );

   always_comb begin
      if (state == ST_SCAN) begin
         drv_on = drv_onehot;
         key_pu_en = !mode_single || scan_no;
         sys_pu_en = !mode_single || !scan_no;
      end else begin
         drv_on = '1;
         key_pu_en = 1'b1;
         sys_pu_en = !mode_single;
      end
   end

   logic             hit_sys, hit_key, sys_seen, key_seen, pass_end, scan_ok;
   logic [SYS_W-1:0] sys_val;
   logic [CMD_W-1:0] cmd_val;

   always_comb begin
      hit_sys  = slot_end && legal && is_sys;
      hit_key  = slot_end && legal && !is_sys;
      sys_seen = sys_hit_q || hit_sys;
      key_seen = key_hit_q || hit_key;
      pass_end = slot_end && (drv_idx == DRV_W'(N_DRV - 1));
      scan_ok  = mode_single ? key_seen : (sys_seen || key_seen);
      sys_val  = SYS_W'(int'(sys_idx) * N_DRV + int'(drv_idx));
      cmd_val  = CMD_W'(int'(drv_idx) * N_KEY + int'(key_idx));
   end

   assign session_on = (state == ST_SCAN) || (state == ST_WAIT);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state       <= ST_IDLE;
         tick_cnt    <= '0;
         sys_hit_q   <= 1'b0;
         key_hit_q   <= 1'b0;
         sys_id      <= '0;
         cmd_id      <= '0;
         code_req    <= 1'b0;
         abort_pulse <= 1'b0;
      end else begin
         code_req    <= 1'b0;
         abort_pulse <= 1'b0;
         unique case (state)
            ST_IDLE: begin
               if (legal) begin
                  state    <= ST_DEB;
                  tick_cnt <= '0;
               end
            end
            ST_DEB: begin
               if (!legal) begin
                  state       <= ST_IDLE;
                  abort_pulse <= 1'b1;
               end else if (bit_tick) begin
                  if (tick_cnt == CNT_W'(DEB_BITS - 1)) begin
                     state     <= ST_SCAN;
                     sys_hit_q <= 1'b0;
                     key_hit_q <= 1'b0;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
            end
            ST_SCAN: begin
               if (hit_sys) sys_id <= sys_val;
               if (hit_key) cmd_id <= cmd_val;
               sys_hit_q <= sys_seen;
               key_hit_q <= key_seen;
               if (pass_end && !scan_no && mode_single && !sys_seen) begin
                  state       <= ST_IDLE;
                  abort_pulse <= 1'b1;
               end else if (pass_end && scan_no) begin
                  if (scan_ok) begin
                     state    <= ST_WAIT;
                     tick_cnt <= '0;
                     code_req <= 1'b1;
                     if (!mode_single && sys_seen) cmd_id <= '1;
                  end else begin
                     state       <= ST_IDLE;
                     abort_pulse <= 1'b1;
                  end
               end
            end
            ST_WAIT: begin
               if (bit_tick) begin
                  if (tick_cnt == CNT_W'(REPEAT_BITS - 1)) begin
                     sys_hit_q <= 1'b0;
                     key_hit_q <= 1'b0;
                     state     <= legal ? ST_SCAN : ST_IDLE;
                  end else begin
                     tick_cnt <= tick_cnt + 1'b1;
                  end
               end
            end
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/keypad_scan_seq_chk.sv
module keypad_scan_seq_chk #(
   parameter int N_DRV = 8
) (
   input logic             clk,
   input logic             rst_n,
   input logic             mode_single,
   input logic [N_DRV-1:0] drv_on,
   input logic             key_pu_en,
   input logic             sys_pu_en,
   input logic             code_req,
   input logic             session_on,
   input logic             abort_pulse
);
   localparam logic [N_DRV-1:0] ALL_ON = '1;
   localparam logic [N_DRV-1:0] FIRST = N_DRV'(1);
   localparam logic [N_DRV-1:0] LAST = FIRST << (N_DRV - 1);

   // R1
   quiet_drv_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !session_on |-> drv_on == ALL_ON);

   // R5
   scan_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      drv_on != ALL_ON |-> $countones(drv_on) == 1);

   // R5
   scan_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($countones(drv_on) == 1 && $countones($past(drv_on)) == 1) |->
         (drv_on == $past(drv_on) || drv_on == ($past(drv_on) << 1) ||
          (drv_on == FIRST && $past(drv_on) == LAST)));

   // R9
   single_pu_chk: assert property (@(posedge clk) disable iff (!rst_n)
      mode_single |-> !(key_pu_en && sys_pu_en));

   // R13
   req_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_req |=> !code_req);

   // R13
   req_abort_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(code_req && abort_pulse));

   // R12
   req_session_chk: assert property (@(posedge clk) disable iff (!rst_n)
      code_req |-> session_on);

   // R4
   abort_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      abort_pulse |-> (!session_on && drv_on == ALL_ON));
endmodule

bind keypad_scan_seq keypad_scan_seq_chk #(.N_DRV(N_DRV)) u_chk (.*);

// File: tb/keypad_scan_seq_tb.sv
module keypad_scan_seq_tb_top;
   localparam int BIT = 32;
   localparam int DEB = 16;
   localparam int REP = 8;
   localparam int SLOT = BIT / 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       bit_tick = 1'b0;
   logic       mode_single = 1'b0;
   logic [7:0] key_sense_n;
   logic [3:0] sys_sense_n;
   logic [7:0] drv_on;
   logic       key_pu_en, sys_pu_en;
   logic [4:0] sys_id;
   logic [5:0] cmd_id;
   logic       code_req, session_on, abort_pulse;

   always #10 clk = ~clk;

   keypad_scan_seq #(.DEB_BITS(DEB), .BIT_CLKS(BIT), .REPEAT_BITS(REP)) dut_i (
      .clk(clk), .rst_n(rst_n), .bit_tick(bit_tick), .mode_single(mode_single),
      .key_sense_n(key_sense_n), .sys_sense_n(sys_sense_n), .drv_on(drv_on),
      .key_pu_en(key_pu_en), .sys_pu_en(sys_pu_en), .sys_id(sys_id),
      .cmd_id(cmd_id), .code_req(code_req), .session_on(session_on),
      .abort_pulse(abort_pulse)
   );

   // keypad model: two contacts and one wired system strap
   logic       a_on = 0, a_sys = 0, b_on = 0, b_sys = 0, w_on = 0;
   logic [2:0] a_idx = 0, b_idx = 0;
   logic [1:0] w_idx = 0;
   logic [7:0] a_ko = 0, b_ko = 0, w_ko = 0;

   always_comb begin
      key_sense_n = '1;
      sys_sense_n = '1;
      if (a_on && |(a_ko & drv_on)) begin
         if (a_sys) sys_sense_n[a_idx[1:0]] = 1'b0;
         else key_sense_n[a_idx] = 1'b0;
      end
      if (b_on && |(b_ko & drv_on)) begin
         if (b_sys) sys_sense_n[b_idx[1:0]] = 1'b0;
         else key_sense_n[b_idx] = 1'b0;
      end
      if (w_on && |(w_ko & drv_on)) sys_sense_n[w_idx] = 1'b0;
   end

   int checks = 0, failures = 0;
   int cyc = 0, code_cnt = 0, abort_cnt = 0, code_cyc = 0;
   int cap_sys = 0, cap_cmd = 0;
   bit done = 0;

   always @(negedge clk) begin
      cyc++;
      if (code_req) begin
         code_cnt++;
         cap_sys = int'(sys_id);
         cap_cmd = int'(cmd_id);
         code_cyc = cyc;
      end
      if (abort_pulse) abort_cnt++;
   end

   initial begin
      @(posedge rst_n);
      forever begin
         repeat (BIT - 1) @(negedge clk);
         bit_tick = 1'b1;
         @(negedge clk);
         bit_tick = 1'b0;
      end
   end

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         failures++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic press_a(input bit sys, input int idx, input logic [7:0] ko);
      a_sys = sys; a_idx = 3'(idx); a_ko = ko; a_on = 1'b1;
   endtask

   task automatic release_all();
      a_on = 0; b_on = 0;
   endtask

   task automatic wait_code(input int c0, input int limit);
      int n = 0;
      while (code_cnt == c0 && n < limit) begin @(negedge clk); n++; end
   endtask

   task automatic settle();
      int n = 0;
      release_all();
      while (session_on && n < (REP + 4) * BIT) begin @(negedge clk); n++; end
      repeat (4) @(negedge clk);
   endtask

   task automatic t_reset();
      chk(drv_on == 8'hFF, "R1 drivers", int'(drv_on), 255);
      chk(!code_req && !session_on && !abort_pulse, "R1 flags",
          int'({code_req, session_on, abort_pulse}), 0);
      chk(sys_id == 0 && cmd_id == 0, "R1 ids", int'({sys_id, cmd_id}), 0);
   endtask

   task automatic t_comb_key();
      int c0 = code_cnt, a0 = abort_cnt, p;
      @(negedge clk);
      press_a(0, 3, 8'h20);
      p = cyc;
      wait_code(c0, 25 * BIT);
      chk(code_cnt == c0 + 1, "R3 request seen", code_cnt - c0, 1);
      chk(code_cyc - p >= 17 * BIT - 2 && code_cyc - p <= 18 * BIT + 6,
          "R3 latency", code_cyc - p, 17 * BIT);
      chk(cap_cmd == 43, "R6 cmd", cap_cmd, 43);
      chk(cap_sys == 0, "R8 initial system kept", cap_sys, 0);
      settle();
      chk(code_cnt == c0 + 1 && abort_cnt == a0, "R12 quiet end without abort",
          abort_cnt - a0, 0);
   endtask

   task automatic t_slots();
      int c0 = code_cnt, n = 0, len = 0;
      @(negedge clk);
      press_a(0, 2, 8'h01);
      while (drv_on != 8'h01 && n < 25 * BIT) begin @(negedge clk); n++; end
      while (drv_on == 8'h01) begin @(negedge clk); len++; end
      chk(len == SLOT, "R5 slot length", len, SLOT);
      chk(drv_on == 8'h02, "R5 next driver", int'(drv_on), 2);
      wait_code(c0, 4 * BIT);
      chk(cap_cmd == 2, "R6 cmd driver 0", cap_cmd, 2);
      settle();
   endtask

   task automatic t_comb_sys();
      int c0 = code_cnt;
      @(negedge clk);
      press_a(1, 2, 8'h40);
      wait_code(c0, 25 * BIT);
      chk(cap_sys == 22, "R7 system", cap_sys, 22);
      chk(cap_cmd == 63, "R7 all-ones command", cap_cmd, 63);
      settle();
   endtask

   task automatic t_keep_sys();
      int c0 = code_cnt;
      @(negedge clk);
      press_a(0, 0, 8'h02);
      wait_code(c0, 25 * BIT);
      chk(cap_sys == 22 && cap_cmd == 8, "R8 stored system with new cmd",
          cap_sys * 100 + cap_cmd, 2208);
      settle();
   endtask

   task automatic t_multi_ko();
      int c0 = code_cnt;
      @(negedge clk);
      press_a(0, 1, 8'h84);
      wait_code(c0, 25 * BIT);
      chk(cap_cmd == 57, "R6 last driver wins", cap_cmd, 57);
      settle();
   endtask

   task automatic t_illegal(input bit b_is_sys, input int bi, input logic [7:0] bko);
      int c0 = code_cnt, a0 = abort_cnt;
      @(negedge clk);
      press_a(0, 1, 8'h04);
      b_sys = b_is_sys; b_idx = 3'(bi); b_ko = bko; b_on = 1'b1;
      repeat (20 * BIT) @(negedge clk);
      chk(!session_on && code_cnt == c0 && abort_cnt == a0,
          b_is_sys ? "R2 key plus system" : "R2 two keys", code_cnt - c0, 0);
      settle();
   endtask

   task automatic t_bounce();
      int c0 = code_cnt, a0 = abort_cnt;
      @(negedge clk);
      press_a(0, 4, 8'h08);
      repeat (5 * BIT) @(negedge clk);
      release_all();
      repeat (3) @(negedge clk);
      chk(abort_cnt == a0 + 1, "R4 abort on early release", abort_cnt - a0, 1);
      chk(drv_on == 8'hFF && !session_on, "R4 quiescent", int'(drv_on), 255);
      repeat (20 * BIT) @(negedge clk);
      chk(code_cnt == c0, "R4 no request", code_cnt - c0, 0);
   endtask

   task automatic t_repeat_takeover();
      int c0 = code_cnt, a0 = abort_cnt, first;
      @(negedge clk);
      press_a(0, 2, 8'h10);
      wait_code(c0, 25 * BIT);
      first = code_cyc;
      chk(cap_cmd == 34, "R11 first code", cap_cmd, 34);
      chk(session_on == 1'b1, "R12 session held", int'(session_on), 1);
      press_a(0, 5, 8'h02);
      wait_code(c0 + 1, (REP + 4) * BIT);
      chk(code_cnt == c0 + 2 && cap_cmd == 13, "R11 takeover code", cap_cmd, 13);
      chk(code_cyc - first >= (REP + 1) * BIT - 2 && code_cyc - first <= (REP + 2) * BIT + 6,
          "R11 repeat interval", code_cyc - first, (REP + 2) * BIT);
      settle();
      chk(abort_cnt == a0 && !session_on, "R12 release between codes", abort_cnt - a0, 0);
   endtask

   task automatic t_single();
      int c0 = code_cnt, n = 0;
      @(negedge clk);
      mode_single = 1'b1;
      w_idx = 2'd1; w_ko = 8'h08; w_on = 1'b1;
      b_sys = 1; b_idx = 3'd2; b_ko = 8'h01; b_on = 1'b1;
      repeat (20 * BIT) @(negedge clk);
      chk(!session_on && code_cnt == c0, "R9 system line cannot start", int'(session_on), 0);
      b_on = 1'b0;
      press_a(0, 0, 8'h80);
      while (drv_on != 8'h01 && n < 25 * BIT) begin @(negedge clk); n++; end
      chk(sys_pu_en && !key_pu_en, "R9 first pass pull-ups",
          int'({sys_pu_en, key_pu_en}), 2);
      while (drv_on == 8'h01) @(negedge clk);
      while (drv_on != 8'h01 && session_on) @(negedge clk);
      chk(!sys_pu_en && key_pu_en, "R9 second pass pull-ups",
          int'({sys_pu_en, key_pu_en}), 1);
      wait_code(c0, 4 * BIT);
      chk(cap_sys == 11, "R9 wired system", cap_sys, 11);
      chk(cap_cmd == 56, "R9 command on last driver", cap_cmd, 56);
      settle();
   endtask

   task automatic t_single_nowire();
      int c0 = code_cnt, a0 = abort_cnt, n = 0;
      @(negedge clk);
      w_on = 1'b0;
      press_a(0, 3, 8'h04);
      while (abort_cnt == a0 && n < 25 * BIT) begin @(negedge clk); n++; end
      chk(abort_cnt == a0 + 1, "R10 abort without strap", abort_cnt - a0, 1);
      chk(code_cnt == c0, "R10 no request", code_cnt - c0, 0);
      settle();
      mode_single = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      rst_n = 1'b1;
      repeat (2) @(negedge clk);
      t_reset();
      t_comb_key();
      t_slots();
      t_comb_sys();
      t_keep_sys();
      t_multi_ko();
      t_illegal(0, 4, 8'h08);
      t_illegal(1, 0, 8'h20);
      t_bounce();
      t_repeat_takeover();
      t_single();
      t_single_nowire();
      if (!done) begin
         done = 1;
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         done = 1;
         checks++;
         failures++;
         $display("FAIL watchdog actual=%0d expected=%0d", cyc, 0);
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end
endmodule